// File: doc/BRIEF.md
# Pattern-RAM Internal Command Sequencer

This block keeps an excitation pattern in an on-chip RAM. A host loads the pattern through a small register interface and replays it as periodic write commands generated inside the chip. The host loads the pattern word by word through an auto-incrementing load pointer. That pointer keeps its value between host transactions, so successive batches of pattern words are appended one after another. The host can move the pointer at any time and read the stored words back through the same pointer.

When the mode register selects pattern playback, a sequencer counts frame boundaries. A frame boundary is marked by a one-cycle `frame_end` pulse at the end of each data packet. Every N boundaries the sequencer fetches the next pattern word and issues one write command on a valid/ready port. The command carries the programmed target card, the target parameter and a word count, and every data word equals the fetched pattern value. Playback always begins at index 0 and wraps after index length-1. Playback ignores the host pointer.

The last command value that was actually accepted is driven on a header output, for a packet builder to place into its fixed ramp-value header word. In ramp mode that output carries an external ramp value instead.

Top module: `pat_cmd_seq`

## Requirements
- R1: A host write with select 3 (pattern data) stores `reg_wdata` at the host pointer, and the pointer then advances by one. The pointer is never reset by the end of a transaction, so separate writes append.
- R2: A host read (`reg_rd` high, `reg_wr` low) raises `reg_rvalid` with `reg_rdata` on the following cycle. With select 3 the read returns the RAM word at the host pointer, and the pointer then advances by one.
- R3: The register selects are: 0 mode, 1 sequence length, 2 host pointer, 4 step period, 5 card address, 6 parameter ID, 7 words per command. Each reads back what was written. A length above DEPTH is stored as DEPTH.
- R4: Playback reads RAM index 0 first and wraps to index 0 after index length-1, whatever the host pointer holds.
- R5: Commands are issued only while mode equals 3, the length is non-zero and the step period is non-zero.
- R6: One command is issued for every N `frame_end` pulses, where N is the step period. `cmd_valid` rises on the cycle after the pulse that completes the count.
- R7: Each command carries the programmed card address, parameter ID and words-per-command count, and `cmd_data` is the pattern word at the current playback index.
- R8: `hdr_ramp_value` resets to 0. Outside mode 2 it changes only on the cycle after a command is accepted, and it then shows the accepted `cmd_data`.
- R9: A presented command stays valid, with all its fields stable, until `cmd_ready` accepts it. This holds even if the mode leaves 3.
- R10: While playback is not enabled, the playback index and the frame count are held at 0. After playback is re-enabled, the next command uses index 0.
- R11: In mode 2, `hdr_ramp_value` follows `ramp_val_i`.
- R12: A step that falls due while a command is still waiting is dropped, and the playback index does not advance for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_sel | input | 3 | Host register select |
| reg_wdata | input | DW | Host write data |
| reg_rdata | output | DW | Host read data, one cycle after the read strobe |
| reg_rvalid | output | 1 | Read data valid |
| frame_end | input | 1 | One-cycle pulse at each data packet end |
| ramp_val_i | input | DW | Ramp value reported in mode 2 |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command accepted by the consumer |
| cmd_card | output | CW | Target card address |
| cmd_param | output | IW | Target parameter ID |
| cmd_words | output | NW | Number of data words in the command |
| cmd_data | output | DW | Value of every data word |
| hdr_ramp_value | output | DW | Value for the packet header ramp word |

## Verification
Host read data and `reg_rvalid` are due one clock after the read strobe. The bench drives each strobe for one cycle from a falling edge and samples at the next falling edge. A command is due one clock after the `frame_end` pulse that completes the step count, and the bench samples `cmd_valid` and the command fields at the falling edge right after that pulse. The header value is due one clock after acceptance, so it is checked one falling edge after the accepting edge. The mode-2 value is combinational and is checked right after the mode write. Command counts and values are taken by a monitor at each accepting edge, and are compared after whole frame bursts have finished.

// File: rtl/pat_pkg.sv
package pat_pkg;

  typedef enum logic [2:0] {
    SEL_MODE   = 3'd0,
    SEL_LEN    = 3'd1,
    SEL_HPTR   = 3'd2,
    SEL_PAT    = 3'd3,
    SEL_PERIOD = 3'd4,
    SEL_CARD   = 3'd5,
    SEL_PARAM  = 3'd6,
    SEL_WORDS  = 3'd7
  } reg_sel_e;

  localparam logic [1:0] MODE_RAMP    = 2'd2;
  localparam logic [1:0] MODE_PATTERN = 2'd3;

  // Next playback index: wraps to zero at or beyond the last valid index.
  function automatic int next_index(input int idx, input int len);
    return (idx + 1 >= len) ? 0 : idx + 1;
  endfunction

  // A step falls due when this frame completes the programmed count.
  function automatic bit step_due(input int cnt, input int per);
    return (cnt + 1 >= per);
  endfunction

  // Sequence length is limited to the RAM depth.
  function automatic int clamp_len(input logic [31:0] v, input int depth);
    return (v > 32'(depth)) ? depth : int'(v);
  endfunction

endpackage

// File: rtl/pat_ram.sv
module pat_ram #(
  parameter int DEPTH = 2048,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          a_en,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_q,
  input  logic          b_en,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_q
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Host read port
  always_ff @(posedge clk) begin
    if (a_en) a_q <= mem[a_addr];
  end

  // Playback read port; output holds until the next fetch
  always_ff @(posedge clk) begin
    if (b_en) b_q <= mem[b_addr];
  end

endmodule

// File: rtl/pat_host_regs.sv
module pat_host_regs
  import pat_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int DW    = 32,
  parameter int PW    = 16,
  parameter int CW    = 8,
  parameter int IW    = 8,
  parameter int NW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          reg_rvalid,
  output logic [1:0]    mode_o,
  output logic [LW-1:0] len_o,
  output logic [PW-1:0] period_o,
  output logic [CW-1:0] card_o,
  output logic [IW-1:0] param_o,
  output logic [NW-1:0] words_o,
  output logic [AW-1:0] hptr_o,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_ren,
  output logic [AW-1:0] ram_raddr,
  input  logic [DW-1:0] ram_rq
);

  reg_sel_e      sel;
  reg_sel_e      sel_q;
  logic          rd_go;
  logic [DW-1:0] rd_val;
  logic [DW-1:0] val_q;

  assign sel   = reg_sel_e'(reg_sel);
  assign rd_go = reg_rd & ~reg_wr;

  assign ram_we    = reg_wr && (sel == SEL_PAT);
  assign ram_waddr = hptr_o;
  assign ram_wdata = reg_wdata;
  assign ram_ren   = rd_go && (sel == SEL_PAT);
  assign ram_raddr = hptr_o;

  always_comb begin
    rd_val = '0;
    case (sel)
      SEL_MODE:   rd_val[1:0]    = mode_o;
      SEL_LEN:    rd_val[LW-1:0] = len_o;
      SEL_HPTR:   rd_val[AW-1:0] = hptr_o;
      SEL_PERIOD: rd_val[PW-1:0] = period_o;
      SEL_CARD:   rd_val[CW-1:0] = card_o;
      SEL_PARAM:  rd_val[IW-1:0] = param_o;
      SEL_WORDS:  rd_val[NW-1:0] = words_o;
      default:    rd_val         = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_o     <= '0;
      len_o      <= '0;
      period_o   <= '0;
      card_o     <= '0;
      param_o    <= '0;
      words_o    <= '0;
      hptr_o     <= '0;
      reg_rvalid <= 1'b0;
      sel_q      <= SEL_MODE;
      val_q      <= '0;
    end else begin
      reg_rvalid <= rd_go;
      if (rd_go) begin
        sel_q <= sel;
        val_q <= rd_val;
      end
      if (reg_wr) begin
        case (sel)
          SEL_MODE:   mode_o   <= reg_wdata[1:0];
          SEL_LEN:    len_o    <= LW'(clamp_len(32'(reg_wdata), DEPTH));
          SEL_HPTR:   hptr_o   <= reg_wdata[AW-1:0];
          SEL_PAT:    hptr_o   <= hptr_o + 1'b1;
          SEL_PERIOD: period_o <= reg_wdata[PW-1:0];
          SEL_CARD:   card_o   <= reg_wdata[CW-1:0];
          SEL_PARAM:  param_o  <= reg_wdata[IW-1:0];
          SEL_WORDS:  words_o  <= reg_wdata[NW-1:0];
          default:    ;
        endcase
      end else if (ram_ren) begin
        hptr_o <= hptr_o + 1'b1;
      end
    end
  end

  assign reg_rdata = (sel_q == SEL_PAT) ? ram_rq : val_q;

endmodule

// File: rtl/pat_play_fsm.sv
module pat_play_fsm
  import pat_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int DW    = 32,
  parameter int PW    = 16,
  parameter int CW    = 8,
  parameter int IW    = 8,
  parameter int NW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic [LW-1:0] len_i,
  input  logic [PW-1:0] period_i,
  input  logic [CW-1:0] card_i,
  input  logic [IW-1:0] param_i,
  input  logic [NW-1:0] words_i,
  input  logic          frame_end,
  input  logic          cmd_ready,
  input  logic [DW-1:0] ram_q,
  output logic          ram_ren,
  output logic [AW-1:0] ram_raddr,
  output logic          cmd_valid,
  output logic [CW-1:0] cmd_card,
  output logic [IW-1:0] cmd_param,
  output logic [NW-1:0] cmd_words,
  output logic [DW-1:0] applied_o,
  output logic          running_o,
  output logic          step_fire_o,
  output logic          cmd_accept_o,
  output logic [AW-1:0] play_idx_o,
  output logic [PW-1:0] frame_cnt_o
);

  logic due;

  assign running_o    = (mode_i == MODE_PATTERN) && (len_i != '0) && (period_i != '0);
  assign due          = step_due(int'(frame_cnt_o), int'(period_i));
  assign step_fire_o  = running_o && frame_end && due && !cmd_valid;
  assign cmd_accept_o = cmd_valid && cmd_ready;

  assign ram_ren   = step_fire_o;
  assign ram_raddr = play_idx_o;

  // Frame pacing and playback index
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_cnt_o <= '0;
      play_idx_o  <= '0;
    end else if (!running_o) begin
      frame_cnt_o <= '0;
      play_idx_o  <= '0;
    end else if (frame_end) begin
      frame_cnt_o <= due ? '0 : frame_cnt_o + 1'b1;
      if (step_fire_o)
        play_idx_o <= AW'(next_index(int'(play_idx_o), int'(len_i)));
    end
  end

  // Command presentation, held until accepted
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_card  <= '0;
      cmd_param <= '0;
      cmd_words <= '0;
    end else if (step_fire_o) begin
      cmd_valid <= 1'b1;
      cmd_card  <= card_i;
      cmd_param <= param_i;
      cmd_words <= words_i;
    end else if (cmd_accept_o) begin
      cmd_valid <= 1'b0;
    end
  end

  // Last applied value
  always_ff @(posedge clk) begin
    if (!rst_n)            applied_o <= '0;
    else if (cmd_accept_o) applied_o <= ram_q;
  end

endmodule

// File: rtl/pat_cmd_seq.sv
module pat_cmd_seq
  import pat_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int DW    = 32,
  parameter int PW    = 16,
  parameter int CW    = 8,
  parameter int IW    = 8,
  parameter int NW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          reg_rvalid,
  input  logic          frame_end,
  input  logic [DW-1:0] ramp_val_i,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [CW-1:0] cmd_card,
  output logic [IW-1:0] cmd_param,
  output logic [NW-1:0] cmd_words,
  output logic [DW-1:0] cmd_data,
  output logic [DW-1:0] hdr_ramp_value
);

  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  // Named internal events, visible to the bound checker
  logic [1:0]    mode;
  logic [LW-1:0] seq_len;
  logic [PW-1:0] period;
  logic [CW-1:0] card;
  logic [IW-1:0] param;
  logic [NW-1:0] words;
  logic [AW-1:0] host_ptr;
  logic          running;
  logic          step_fire;
  logic          cmd_accept;
  logic [AW-1:0] play_idx;
  logic [PW-1:0] frame_cnt;
  logic [DW-1:0] applied;

  logic          h_we;
  logic [AW-1:0] h_waddr;
  logic [DW-1:0] h_wdata;
  logic          h_ren;
  logic [AW-1:0] h_raddr;
  logic [DW-1:0] h_rq;
  logic          p_ren;
  logic [AW-1:0] p_raddr;

  pat_host_regs #(
    .DEPTH(DEPTH), .DW(DW), .PW(PW), .CW(CW), .IW(IW), .NW(NW)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .mode_o(mode), .len_o(seq_len), .period_o(period),
    .card_o(card), .param_o(param), .words_o(words), .hptr_o(host_ptr),
    .ram_we(h_we), .ram_waddr(h_waddr), .ram_wdata(h_wdata),
    .ram_ren(h_ren), .ram_raddr(h_raddr), .ram_rq(h_rq)
  );

  pat_ram #(.DEPTH(DEPTH), .DW(DW)) ram_i (
    .clk(clk),
    .we(h_we), .waddr(h_waddr), .wdata(h_wdata),
    .a_en(h_ren), .a_addr(h_raddr), .a_q(h_rq),
    .b_en(p_ren), .b_addr(p_raddr), .b_q(cmd_data)
  );

  pat_play_fsm #(
    .DEPTH(DEPTH), .DW(DW), .PW(PW), .CW(CW), .IW(IW), .NW(NW)
  ) play_i (
    .clk(clk), .rst_n(rst_n),
    .mode_i(mode), .len_i(seq_len), .period_i(period),
    .card_i(card), .param_i(param), .words_i(words),
    .frame_end(frame_end), .cmd_ready(cmd_ready), .ram_q(cmd_data),
    .ram_ren(p_ren), .ram_raddr(p_raddr),
    .cmd_valid(cmd_valid), .cmd_card(cmd_card), .cmd_param(cmd_param),
    .cmd_words(cmd_words), .applied_o(applied),
    .running_o(running), .step_fire_o(step_fire), .cmd_accept_o(cmd_accept),
    .play_idx_o(play_idx), .frame_cnt_o(frame_cnt)
  );

  assign hdr_ramp_value = (mode == MODE_RAMP) ? ramp_val_i : applied;

endmodule

// File: rtl/pat_cmd_seq_chk.sv
module pat_cmd_seq_chk #(
  parameter int DW = 32,
  parameter int AW = 11,
  parameter int PW = 16,
  parameter int CW = 8,
  parameter int IW = 8,
  parameter int NW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [2:0]    reg_sel,
  input logic          reg_rvalid,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [CW-1:0] cmd_card,
  input logic [IW-1:0] cmd_param,
  input logic [NW-1:0] cmd_words,
  input logic [DW-1:0] cmd_data,
  input logic [DW-1:0] hdr_ramp_value,
  input logic [1:0]    mode,
  input logic          running,
  input logic          cmd_accept,
  input logic [AW-1:0] host_ptr,
  input logic [AW-1:0] play_idx,
  input logic [PW-1:0] frame_cnt
);

  AST_PTR_APPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 3'd3) |=> host_ptr == $past(host_ptr) + 1'b1); // R1

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr) |=> reg_rvalid); // R2

  AST_NO_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !cmd_valid) |=> !cmd_valid); // R5

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_valid && $stable(cmd_data) && $stable(cmd_card)
      && $stable(cmd_param) && $stable(cmd_words)); // R9

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (play_idx == '0) && (frame_cnt == '0)); // R10

  AST_HDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd2 && !cmd_accept) ##1 (mode != 2'd2) |-> $stable(hdr_ramp_value)); // R8

  AST_HDR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd2 && cmd_accept) ##1 (mode != 2'd2) |-> hdr_ramp_value == $past(cmd_data)); // R8

endmodule

bind pat_cmd_seq pat_cmd_seq_chk #(
  .DW(DW), .AW(AW), .PW(PW), .CW(CW), .IW(IW), .NW(NW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
  .reg_rvalid(reg_rvalid), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_card(cmd_card), .cmd_param(cmd_param), .cmd_words(cmd_words),
  .cmd_data(cmd_data), .hdr_ramp_value(hdr_ramp_value), .mode(mode),
  .running(running), .cmd_accept(cmd_accept), .host_ptr(host_ptr),
  .play_idx(play_idx), .frame_cnt(frame_cnt)
);

// File: tb/pat_cmd_seq_tb_top.sv
module pat_cmd_seq_tb_top;

  localparam int DW    = 32;
  localparam int DEPTH = 2048;
  localparam int NV    = 20;

  // Register selects (R3)
  localparam logic [2:0] S_MODE = 3'd0, S_LEN = 3'd1, S_HPTR = 3'd2, S_PAT = 3'd3;
  localparam logic [2:0] S_PER = 3'd4, S_CARD = 3'd5, S_PARAM = 3'd6, S_WORDS = 3'd7;

  // Vector table: op 0 = write, 1 = read and compare
  localparam bit          VOP  [NV] = '{0,0,0,0,0,0,1,1,1,1,1,0,1,1,0,1,0,1,0,1};
  localparam logic [2:0]  VSEL [NV] = '{S_HPTR,S_PAT,S_PAT,S_PAT,S_PAT,S_HPTR,S_PAT,S_PAT,
                                        S_PAT,S_PAT,S_HPTR,S_HPTR,S_PAT,S_HPTR,S_LEN,S_LEN,
                                        S_LEN,S_LEN,S_PER,S_PER};
  localparam logic [31:0] VDAT [NV] = '{0,11,22,33,44,0,0,0,0,0,0,2,0,0,99999,0,7,0,5,0};
  localparam logic [31:0] VEXP [NV] = '{0,0,0,0,0,0,11,22,33,44,4,0,33,3,0,DEPTH,0,7,0,5};
  localparam string       VTAG [NV] = '{"R3","R1","R1","R1","R1","R3","R2","R2","R2","R1",
                                        "R2","R3","R2","R2","R3","R3","R3","R3","R3","R3"};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]    reg_sel = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          reg_rvalid;
  logic          frame_end = 1'b0;
  logic [DW-1:0] ramp_val_i = '0;
  logic          cmd_valid;
  logic          cmd_ready = 1'b1;
  logic [7:0]    cmd_card, cmd_param, cmd_words;
  logic [DW-1:0] cmd_data;
  logic [DW-1:0] hdr_ramp_value;

  int checks = 0;
  int failures = 0;
  int acc_n = 0;
  logic [DW-1:0] acc_data [64];

  always #2 clk = ~clk;

  pat_cmd_seq #(.DEPTH(DEPTH), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .frame_end(frame_end), .ramp_val_i(ramp_val_i), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_card(cmd_card), .cmd_param(cmd_param),
    .cmd_words(cmd_words), .cmd_data(cmd_data), .hdr_ramp_value(hdr_ramp_value)
  );

  // Accepted-command monitor
  always @(posedge clk) begin
    if (rst_n && cmd_valid && cmd_ready && acc_n < 64) begin
      acc_data[acc_n] <= cmd_data;
      acc_n <= acc_n + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] sel, output logic [31:0] d, output logic v);
    @(negedge clk); reg_rd = 1'b1; reg_sel = sel;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata; v = reg_rvalid;
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); frame_end = 1'b1;
      @(negedge clk); frame_end = 1'b0;
      repeat (6) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        rv;
    int          base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset hdr", hdr_ramp_value, 0);
    check("R6 reset cmd_valid", {31'b0, cmd_valid}, 0);
    check("R2 reset rvalid", {31'b0, reg_rvalid}, 0);

    // Host register vectors
    for (int k = 0; k < NV; k++) begin
      if (VOP[k] == 1'b0) host_wr(VSEL[k], VDAT[k]);
      else begin
        host_rd(VSEL[k], rd, rv);
        check({VTAG[k], " rvalid"}, {31'b0, rv}, 1);
        check({VTAG[k], " rdata"}, rd, VEXP[k]);
      end
    end

    // Playback setup; host pointer left at 1 (R4: ignored by playback)
    host_wr(S_HPTR, 0);
    host_wr(S_PAT, 100); host_wr(S_PAT, 101); host_wr(S_PAT, 102);
    host_wr(S_LEN, 3); host_wr(S_PER, 2);
    host_wr(S_CARD, 5); host_wr(S_PARAM, 153); host_wr(S_WORDS, 4);
    host_wr(S_HPTR, 1);
    host_wr(S_MODE, 3);
    base = acc_n;

    frames(1);
    check("R6 no command after one frame", acc_n - base, 0);
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
    check("R6 cmd_valid one cycle after due frame", {31'b0, cmd_valid}, 1);
    check("R4 first value from index 0", cmd_data, 100);
    check("R7 card", {24'b0, cmd_card}, 5);
    check("R7 param", {24'b0, cmd_param}, 153);
    check("R7 words", {24'b0, cmd_words}, 4);
    @(negedge clk);
    check("R8 hdr after accept", hdr_ramp_value, 100);
    repeat (5) @(negedge clk);

    frames(6);
    check("R6 commands per frames", acc_n - base, 4);
    check("R4 second", acc_data[base+1], 101);
    check("R4 third", acc_data[base+2], 102);
    check("R4 wrap to index 0", acc_data[base+3], 100);

    // Backpressure and skipped step
    cmd_ready = 1'b0;
    frames(2);
    check("R9 pending valid", {31'b0, cmd_valid}, 1);
    check("R7 pending data", cmd_data, 101);
    check("R8 hdr unchanged before accept", hdr_ramp_value, 100);
    frames(2);
    check("R9 still pending", cmd_data, 101);
    cmd_ready = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R8 hdr after late accept", hdr_ramp_value, 101);
    frames(2);
    check("R12 skipped step does not advance", acc_data[acc_n-1], 102);

    // Leaving mode 3 with a command pending
    cmd_ready = 1'b0;
    frames(2);
    host_wr(S_MODE, 0);
    check("R9 held after mode exit", {31'b0, cmd_valid}, 1);
    check("R9 held data", cmd_data, 100);
    cmd_ready = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R8 hdr after exit accept", hdr_ramp_value, 100);
    base = acc_n;
    frames(4);
    check("R5 no commands when mode is 0", acc_n - base, 0);
    host_wr(S_MODE, 3);
    frames(2);
    check("R10 restart count", acc_n - base, 1);
    check("R10 restart from index 0", acc_data[acc_n-1], 100);

    // Zero length and zero period
    base = acc_n;
    host_wr(S_LEN, 0);
    frames(4);
    check("R5 zero length idle", acc_n - base, 0);
    host_wr(S_LEN, 3); host_wr(S_PER, 0);
    frames(4);
    check("R5 zero period idle", acc_n - base, 0);

    // Ramp mode header
    ramp_val_i = 777;
    host_wr(S_MODE, 2);
    check("R11 ramp value on header", hdr_ramp_value, 777);
    ramp_val_i = 778;
    @(negedge clk);
    check("R11 header follows ramp", hdr_ramp_value, 778);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule